// File: doc/BRIEF.md
# Oversampling Resolution-Enhancing Decimator

This block trades sample rate for resolution on the data stream from a low-resolution ADC. Each accepted input sample is marked by a valid strobe. The block adds up non-overlapping groups of 4^n consecutive accepted samples, where n is a static parameter. For each group it emits one word: the group sum divided by 2^n, rounded toward minus infinity. Because the sum is divided by 2^n and not by 4^n, the output is the group mean carried with n fractional bits. The output word is therefore n bits wider than the input word.

The gain in resolution is only real when the analog input moves by a few input LSBs from sample to sample. The design assumes that an analog source outside the block supplies zero-mean dither of about one input LSB. Input samples may be two's complement or unsigned, chosen by a parameter. The output uses the same encoding as the input.

Top module: `osr_decimator`

## Requirements
- R1: After every 4^n accepted samples (4^EXTRA; 16 at the default EXTRA=2), `out_valid` is high for exactly one cycle. That cycle is the clock cycle directly after the edge that accepts the last sample of the group.
- R2: With SIGNED_IN=1, `out_data` (IN_W+EXTRA bits, two's complement) equals the sum of the group's samples, read as two's complement, divided by 2^EXTRA and rounded toward minus infinity. For example, a group that sums to -1 gives -1.
- R3: A group in which every sample is at the most negative or the most positive input code produces the exact floor(sum/2^EXTRA) with no wrap. At the defaults these results are -512 and 508.
- R4: A cycle with `in_valid` low does not change the group contents or the group position, whatever `in_data` holds. `out_valid` is high only in the cycle directly after a completing accepted sample.
- R5: `out_data` keeps its value in every cycle in which `out_valid` is low.
- R6: The synchronous, active-high `rst` drives `out_valid` and `out_data` to 0 and discards a partly filled group. The first group after reset holds only samples accepted after reset.
- R7: With SIGNED_IN=0, input samples are read as unsigned, and `out_data` is floor(unsigned sum / 2^EXTRA) as an unsigned value.
- R8: Groups follow one another with no gap. With `in_valid` held high, the sample accepted in the same cycle as a group's output pulse is the first sample of the next group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_data` holds a sample to accept |
| in_data | input | IN_W | ADC sample, two's complement or unsigned per SIGNED_IN |
| out_valid | output | 1 | One-cycle pulse per completed group |
| out_data | output | IN_W+EXTRA | Group sum divided by 2^EXTRA |

## Verification
A wrong group position shows at the ports as an `out_valid` pulse a few cycles early or late. A wrong running sum shows as a wrong `out_data` value at the next pulse, at most 4^n accepted samples later. Sign-extension and overflow faults only show at full-scale or negative inputs, so these are driven as directed corner cases. Faults in reset handling and in how idle cycles are treated only show when a reset or a run of invalid cycles falls in the middle of a group, so the stimulus places both there.

// File: rtl/osr_decimator.sv
module osr_decimator #(
  parameter int IN_W      = 8,
  parameter int EXTRA     = 2,
  parameter bit SIGNED_IN = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [IN_W-1:0]       in_data,
  output logic                  out_valid,
  output logic [IN_W+EXTRA-1:0] out_data
);
  localparam int GROUP = 4 ** EXTRA;
  localparam int ACC_W = IN_W + 2 * EXTRA;
  localparam int OUT_W = IN_W + EXTRA;
  localparam int CNT_W = 2 * EXTRA;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP - 1);

  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] ext;
  logic [ACC_W-1:0] sum;
  logic             done;

  generate
    if (SIGNED_IN) begin : g_sext
      assign ext = {{(2 * EXTRA){in_data[IN_W-1]}}, in_data};
    end else begin : g_zext
      assign ext = {{(2 * EXTRA){1'b0}}, in_data};
    end
  endgenerate

  assign sum  = acc + ext;
  assign done = in_valid && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= done;
      if (in_valid) begin
        cnt <= cnt + 1'b1;
        acc <= done ? '0 : sum;
      end
      if (done) out_data <= OUT_W'(sum[ACC_W-1:EXTRA]);
    end
  end
endmodule

// File: rtl/osr_decimator_chk.sv
module osr_decimator_chk #(
  parameter int IN_W  = 8,
  parameter int EXTRA = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [IN_W-1:0]       in_data,
  input logic                  out_valid,
  input logic [IN_W+EXTRA-1:0] out_data
);
  localparam int CNT_W = 2 * EXTRA;
  localparam logic [CNT_W-1:0] LAST = CNT_W'((4 ** EXTRA) - 1);

  logic [CNT_W-1:0] ccnt = '0;
  logic seen  = 1'b0;
  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ccnt  <= '0;
      seen  <= 1'b1;
      armed <= 1'b0;
    end else begin
      armed <= seen;
      if (in_valid) ccnt <= ccnt + 1'b1;
    end
  end

  a_r1_pulse_after_group: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(in_valid && ccnt == LAST) |-> out_valid);

  a_r4_no_stray_pulse: assert property (@(posedge clk) disable iff (rst || !armed)
    out_valid |-> $past(in_valid && ccnt == LAST));

  a_r1_single_cycle: assert property (@(posedge clk) disable iff (rst || !armed)
    out_valid |=> !out_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    !out_valid |-> $stable(out_data));

  a_r6_reset_clear: assert property (@(posedge clk) disable iff (!seen)
    $past(rst) |-> (!out_valid && out_data == '0));
endmodule

bind osr_decimator osr_decimator_chk #(.IN_W(IN_W), .EXTRA(EXTRA)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/osr_decimator_bench.sv
module osr_decimator_bench;
  localparam int W  = 8;
  localparam int NS = 2;
  localparam int NU = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic [W-1:0] din = '0;
  logic s_ov, u_ov;
  logic [W+NS-1:0] s_od;
  logic [W+NU-1:0] u_od;

  int checks = 0, errors = 0;
  int s_sum = 0, s_cnt = 0, u_sum = 0, u_cnt = 0;
  int s_exp = 0, u_exp = 0;
  bit s_pulse = 0, u_pulse = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  osr_decimator #(.IN_W(W), .EXTRA(NS), .SIGNED_IN(1'b1)) u_osr_decimator (
    .clk(clk), .rst(rst), .in_valid(vld), .in_data(din),
    .out_valid(s_ov), .out_data(s_od));

  osr_decimator #(.IN_W(W), .EXTRA(NU), .SIGNED_IN(1'b0)) u_osr_decimator_uns (
    .clk(clk), .rst(rst), .in_valid(vld), .in_data(din),
    .out_valid(u_ov), .out_data(u_od));

  function automatic int floor_shift(int v, int n);
    return v >>> n;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(s_ov == s_pulse, {req, " signed valid R1/R4"}, int'(s_ov), int'(s_pulse));
    chk($signed(s_od) == s_exp, {req, " signed data R2/R5"}, int'($signed(s_od)), s_exp);
    chk(u_ov == u_pulse, {req, " unsigned valid R7"}, int'(u_ov), int'(u_pulse));
    chk(int'(u_od) == u_exp, {req, " unsigned data R7"}, int'(u_od), u_exp);
  endtask

  task automatic step(bit v, logic [W-1:0] d, string req);
    vld = v; din = d;
    s_pulse = 0; u_pulse = 0;
    if (v) begin
      s_sum += int'($signed(d)); s_cnt++;
      u_sum += int'(d);          u_cnt++;
      if (s_cnt == 4 ** NS) begin
        s_exp = floor_shift(s_sum, NS); s_pulse = 1; s_sum = 0; s_cnt = 0;
      end
      if (u_cnt == 4 ** NU) begin
        u_exp = floor_shift(u_sum, NU); u_pulse = 1; u_sum = 0; u_cnt = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset();
    rst = 1; vld = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    s_sum = 0; s_cnt = 0; u_sum = 0; u_cnt = 0;
    s_exp = 0; u_exp = 0; s_pulse = 0; u_pulse = 0;
    compare("R6 reset");
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    do_reset();
    for (int i = 0; i < 16; i++) step(1'b1, 8'h80, "R3 min");
    for (int i = 0; i < 16; i++) step(1'b1, 8'h7F, "R3 max");
    step(1'b1, 8'hFF, "R2 floor");
    for (int i = 0; i < 15; i++) step(1'b1, 8'h00, "R2 floor");
    for (int i = 0; i < 5; i++) step(1'b1, 8'(i * 3 + 1), "R6 partial");
    do_reset();
    for (int i = 0; i < 16; i++) step(1'b1, 8'(i + 10), "R6 fresh group");
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 8'($urandom), "R4 idle");
      if (i % 3 == 0) step(1'b1, 8'($urandom_range(0, 6) + 60), "R4 sparse");
    end
    for (int i = 0; i < 64; i++) step(1'b1, 8'($urandom), "R8 back-to-back");
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, 8'($urandom_range(0, 4) + 8'(i % 200)), "R2 random");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule